// File: doc/BRIEF.md
# Masked GPIO Bank with Automatic Transmit/Receive Override

This block is a bank of general-purpose pins for two radio sides. Each side owns a transmit pin group and a receive pin group of 16 pins each. Every group keeps an output-enable register and an output-level register. Software changes them through a single 32-bit write: the upper half selects which bits change, and the lower half gives their new values. Bits that are not selected keep what they held, so one routine can flip an antenna switch without disturbing a mixer enable that another routine owns.

Each group also has an automatic override made of three registers: a pin mask, a level used while the side transmits and a level used while it receives. On masked pins the per-side `tx_active` input chooses between those two levels, and the pin follows the radio state with no software write. A mask of zero turns the override off. The external pin levels pass through a two-stage synchronizer. A read of a side's level word returns both groups together, which is how input pins such as a lock indicator are observed. Pins reset as inputs.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is 0, so `pad_oe` and `pad_out` are all 0, `rd_valid` is 0 and a level read shows only the external pin levels.
- R2: A write word carries a change mask in bits 31:16 and new values in bits 15:0. Only register bits whose mask bit is 1 take the new value. A write with a zero mask changes nothing.
- R3: Output enable and output level are separate registers. A write to one never alters the other.
- R4: Address bits [ADDR_W-1:4] select the side and bits [3:0] the register: 0 tx-group OE, 1 rx-group OE, 2 tx IO, 3 rx IO, 4 tx override mask, 5 rx override mask, 6 tx transmit level, 7 rx transmit level, 8 tx receive level, 9 rx receive level, 15 level readback. Writes to offsets 10 to 15 have no effect.
- R5: A read request (`rd_en`) gives `rd_valid` high for exactly the next cycle. `rd_data` then holds the rx-group pin levels in bits 31:16 and the tx-group levels in bits 15:0 for offset 15, and 0 for any other offset.
- R6: A pin whose OE bit is 0 is not driven (`pad_oe` bit 0), and the readback shows its external level. A pin whose OE bit is 1 reads back its own driven level.
- R7: On a pin whose override-mask bit is 1, `pad_out` is the transmit level while `tx_active` of that side is 1 and the receive level while it is 0. On other pins `pad_out` is the IO register. The override never alters `pad_oe`.
- R8: With an all-zero override mask, `tx_active` has no effect on the pins.
- R9: A change of an external level reaches the readback through two flops. A read accepted on either of the first two clock edges after the change returns the old level, and a read accepted on the third edge returns the new level.
- R10: Pad vectors are laid out as group index (side*2 + g, g=0 tx, g=1 rx) times 16 plus the bit number. Writes to one side never change the other side's pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Side and register offset |
| wr_data | input | 32 | Mask in 31:16, values in 15:0 |
| rd_data | output | 32 | Read result, registered |
| rd_valid | output | 1 | Read result valid, one cycle |
| tx_active | input | NUM_SIDES | Per-side transmit state for the override |
| pad_in | input | NUM_SIDES*32 | Resolved pin levels |
| pad_out | output | NUM_SIDES*32 | Driven pin levels |
| pad_oe | output | NUM_SIDES*32 | Pin drive enables |

## Verification
The hardest case to reach is a pin that carries three controls at once: it is enabled, its IO register holds one level, and its override mask picks a different pair of levels. The expected pin level must then follow `tx_active` while the readback mixes driven and external bits. The stimulus builds this state in steps. It first sets the enable and IO bits through partial masks, loads both override levels while the mask is still zero and shows that `tx_active` then does nothing, and only after that sets the mask and toggles `tx_active`. The synchronizer delay is reached by changing an undriven external level and issuing reads on the first and third edges after the change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PIN_W  = 16;
    localparam int WORD_W = 2 * PIN_W;
    localparam int GRPS_PER_SIDE = 2;
    localparam int OFF_W  = 4;

    localparam logic [OFF_W-1:0] OFF_READBACK = 4'hF;

    typedef enum logic [2:0] {
        K_OE    = 3'd0,
        K_IO    = 3'd1,
        K_AMASK = 3'd2,
        K_ATX   = 3'd3,
        K_ARX   = 3'd4
    } reg_kind_e;

    localparam logic [2:0] KIND_LAST = 3'd4;

    typedef struct packed {
        logic [PIN_W-1:0] oe;
        logic [PIN_W-1:0] io;
        logic [PIN_W-1:0] amask;
        logic [PIN_W-1:0] atx;
        logic [PIN_W-1:0] arx;
    } grp_regs_t;

    function automatic logic [PIN_W-1:0] masked_merge(
        input logic [PIN_W-1:0]  old_v,
        input logic [WORD_W-1:0] word
    );
        logic [PIN_W-1:0] m;
        logic [PIN_W-1:0] v;
        m = word[WORD_W-1:PIN_W];
        v = word[PIN_W-1:0];
        return (old_v & ~m) | (v & m);
    endfunction

endpackage

// File: rtl/gpio_grp_regs.sv
module gpio_grp_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [2:0]        kind,
    input  logic [WORD_W-1:0] wr_data,
    output grp_regs_t         regs
);

    grp_regs_t r_d;
    grp_regs_t r_q;

    always_comb begin
        r_d = r_q;
        if (sel) begin
            case (reg_kind_e'(kind))
                K_OE:    r_d.oe    = masked_merge(r_q.oe,    wr_data);
                K_IO:    r_d.io    = masked_merge(r_q.io,    wr_data);
                K_AMASK: r_d.amask = masked_merge(r_q.amask, wr_data);
                K_ATX:   r_d.atx   = masked_merge(r_q.atx,   wr_data);
                K_ARX:   r_d.arx   = masked_merge(r_q.arx,   wr_data);
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_bank_pkg::*;
(
    input  grp_regs_t        regs,
    input  logic             tx_active,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);

    logic [PIN_W-1:0] auto_lvl;

    always_comb begin
        auto_lvl = tx_active ? regs.atx : regs.arx;
        pin_out  = (regs.io & ~regs.amask) | (auto_lvl & regs.amask);
        pin_oe   = regs.oe;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t s_d;
    sync_t s_q;

    always_comb begin
        s_d.s1 = din;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.s2;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_SIDES = 2,
    localparam int SIDE_W = (NUM_SIDES > 1) ? $clog2(NUM_SIDES) : 1,
    localparam int ADDR_W = SIDE_W + OFF_W,
    localparam int NGRP   = NUM_SIDES * GRPS_PER_SIDE,
    localparam int PADS   = NGRP * PIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_valid,
    input  logic [NUM_SIDES-1:0] tx_active,
    input  logic [PADS-1:0]      pad_in,
    output logic [PADS-1:0]      pad_out,
    output logic [PADS-1:0]      pad_oe
);

    logic [SIDE_W-1:0] a_side;
    logic [OFF_W-1:0]  a_off;
    logic [2:0]        a_kind;
    logic              a_kind_ok;

    assign a_side    = addr[ADDR_W-1:OFF_W];
    assign a_off     = addr[OFF_W-1:0];
    assign a_kind    = a_off[OFF_W-1:1];
    assign a_kind_ok = (a_kind <= KIND_LAST);

    logic [PADS-1:0] pad_sync;

    gpio_in_sync #(.WIDTH(PADS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pad_sync)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int SIDE = g / GRPS_PER_SIDE;
        localparam logic GSEL = 1'((g % GRPS_PER_SIDE) != 0);

        logic      sel;
        grp_regs_t regs;

        assign sel = wr_en && a_kind_ok
                  && (a_side == SIDE_W'(SIDE))
                  && (a_off[0] == GSEL);

        gpio_grp_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .kind    (a_kind),
            .wr_data (wr_data),
            .regs    (regs)
        );

        gpio_pin_mux u_mux (
            .regs      (regs),
            .tx_active (tx_active[SIDE]),
            .pin_out   (pad_out[g*PIN_W +: PIN_W]),
            .pin_oe    (pad_oe[g*PIN_W +: PIN_W])
        );
    end

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
    } rd_t;

    rd_t rd_d;
    rd_t rd_q;
    logic [WORD_W-1:0] lvl_word;

    always_comb begin
        lvl_word = '0;
        for (int s = 0; s < NUM_SIDES; s++) begin
            if (a_side == SIDE_W'(s)) begin
                lvl_word = pad_sync[s*WORD_W +: WORD_W];
            end
        end
        rd_d.valid = rd_en;
        rd_d.data  = rd_q.data;
        if (rd_en) begin
            rd_d.data = (a_off == OFF_READBACK && int'(a_side) < NUM_SIDES)
                      ? lvl_word : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_SIDES = 2,
    localparam int PADS = NUM_SIDES * GRPS_PER_SIDE * PIN_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic [NUM_SIDES-1:0] tx_active,
    input logic                 rd_valid,
    input logic [PADS-1:0]      pad_out,
    input logic [PADS-1:0]      pad_oe
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && !rd_valid));

    assert_nomask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[WORD_W-1:PIN_W] == '0) |=>
            (!$stable(tx_active) || ($stable(pad_oe) && $stable(pad_out))));

    assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pad_oe));

    assert_rdvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rdidle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!$stable(tx_active) || $stable(pad_out)));

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_SIDES(NUM_SIDES)) u_chk (.*);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

    localparam int NS   = 2;
    localparam int PADS = NS * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [4:0]      addr = '0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic            rd_valid;
    logic [NS-1:0]   tx_active = '0;
    logic [PADS-1:0] pad_in;
    logic [PADS-1:0] pad_out;
    logic [PADS-1:0] pad_oe;
    logic [PADS-1:0] ext = '0;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_bank #(.NUM_SIDES(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .tx_active(tx_active), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] grp(input logic [PADS-1:0] v, input int s, input int g);
        return v[(s*2+g)*16 +: 16];
    endfunction

    task automatic wr(input logic [4:0] a, input logic [15:0] m, input logic [15:0] v);
        wr_en = 1'b1; addr = a; wr_data = {m, v};
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard whenever a read result is presented
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R5: unexpected rd_valid actual=%h expected=none", rd_data);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle(4);
        chk("R1 pad_oe lo", pad_oe[31:0], 32'h0);
        chk("R1 pad_oe hi", pad_oe[63:32], 32'h0);
        chk("R1 pad_out", pad_out[31:0] | pad_out[63:32], 32'h0);
        chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        rd(5'd15, 32'h0, "R1 readback after reset");
        idle(1);
        chk("R5 rd_valid one cycle", {31'h0, rd_valid}, 32'h0);

        // R6: undriven pins show external levels
        ext[15:0] = 16'hA5C3; ext[31:16] = 16'h0F0F;
        idle(4);
        rd(5'd15, 32'h0F0F_A5C3, "R6 external levels");
        chk("R6 undriven", pad_oe[31:0], 32'h0);

        // R2: masked updates
        wr(5'd0, 16'hFFFF, 16'h00FF);
        wr(5'd2, 16'h00F0, 16'h1234);
        chk("R2 io partial", {16'h0, grp(pad_out,0,0)}, 32'h0030);
        chk("R2 oe full", {16'h0, grp(pad_oe,0,0)}, 32'h00FF);
        wr(5'd2, 16'h000F, 16'hFFFF);
        chk("R2 io low nibble", {16'h0, grp(pad_out,0,0)}, 32'h003F);
        wr(5'd2, 16'h0000, 16'hFFFF);
        chk("R2 zero mask", {16'h0, grp(pad_out,0,0)}, 32'h003F);

        // R3: OE write leaves IO alone; readback mixes driven and external
        wr(5'd0, 16'hFFFF, 16'h0F0F);
        chk("R3 oe new", {16'h0, grp(pad_oe,0,0)}, 32'h0F0F);
        chk("R3 io kept", {16'h0, grp(pad_out,0,0)}, 32'h003F);
        idle(4);
        rd(5'd15, 32'h0F0F_A0CF, "R6 mixed readback");

        // R4: rx group offsets and ignored offsets
        wr(5'd1, 16'hFFFF, 16'hFF00);
        wr(5'd3, 16'hFFFF, 16'h5A00);
        chk("R4 rx oe", {16'h0, grp(pad_oe,0,1)}, 32'hFF00);
        chk("R4 rx io", {16'h0, grp(pad_out,0,1)}, 32'h5A00);
        for (int a = 10; a < 16; a++) wr(5'(a), 16'hFFFF, 16'hFFFF);
        chk("R4 ignored out", pad_out[31:0], 32'h5A00_003F);
        chk("R4 ignored oe", pad_oe[31:0], 32'hFF00_0F0F);

        // R8: override levels loaded but mask zero
        wr(5'd6, 16'hFFFF, 16'h00A0);
        wr(5'd8, 16'hFFFF, 16'h0050);
        tx_active[0] = 1'b1; idle(1);
        chk("R8 no mask tx", {16'h0, grp(pad_out,0,0)}, 32'h003F);
        tx_active[0] = 1'b0; idle(1);
        chk("R8 no mask rx", {16'h0, grp(pad_out,0,0)}, 32'h003F);

        // R7: override active
        wr(5'd4, 16'hFFFF, 16'h00F0);
        chk("R7 receive level", {16'h0, grp(pad_out,0,0)}, 32'h005F);
        tx_active[0] = 1'b1; idle(1);
        chk("R7 transmit level", {16'h0, grp(pad_out,0,0)}, 32'h00AF);
        chk("R7 oe untouched", {16'h0, grp(pad_oe,0,0)}, 32'h0F0F);
        chk("R7 rx group untouched", {16'h0, grp(pad_out,0,1)}, 32'h5A00);

        // R10: other side independent
        wr(5'd16, 16'hFFFF, 16'hFFFF);
        wr(5'd18, 16'hFFFF, 16'h1357);
        chk("R10 side1 out", {16'h0, grp(pad_out,1,0)}, 32'h1357);
        chk("R10 side0 out kept", pad_out[31:0], 32'h5A00_00AF);
        chk("R10 side0 oe kept", pad_oe[31:0], 32'hFF00_0F0F);
        tx_active[1] = 1'b1; idle(1);
        chk("R10 side1 tx no effect", {16'h0, grp(pad_out,1,0)}, 32'h1357);

        // R9: synchronizer latency on an undriven side-1 rx pin group
        idle(4);
        ext[63:48] = 16'hBEEF;
        rd(5'd31, 32'h0000_1357, "R9 first edge old");
        idle(1);
        rd(5'd31, 32'hBEEF_1357, "R9 third edge new");

        // R5: non-readback offset reads zero
        rd(5'd2, 32'h0, "R5 other offset");
        idle(1);
        chk("R5 valid dropped", {31'h0, rd_valid}, 32'h0);

        idle(2);
        chk("R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule